// File: doc/BRIEF.md
# Set/Clear Addressed GPIO Controller

This block controls 32 general-purpose pins, arranged as two banks of 16. Each bank has six configuration registers: drive level, drive enable, input enable, two output-function selects and one input-function select. A 32-bit write to a configuration register sets pins through its low half and clears pins through its high half. Software can therefore change one pin with a single store, with no read-modify-write and no lock. Pins whose bits are zero in both halves keep their state.

Each bank also has a synchronized level read-back and two sticky edge registers, one for rising edges and one for falling edges. Software clears an edge bit by writing one to it. The bus is a plain register interface: address, write data, write strobe and combinational read data. Pins 23, 29, 30 and 31 are reserved. They can never hold a one in any register.

Top module: `gpio_setclr_ctrl`

## Requirements
- R1: A configuration write with bit n (0..15) set in the low half sets that register's bit for pin n of the addressed bank. Other pins and other registers are unchanged.
- R2: A configuration write with bit n+16 set clears that register's bit for pin n. Bits that are zero in both halves leave their pins unchanged.
- R3: When a write has both the set bit and the clear bit of one pin, the pin ends up cleared.
- R4: Register offsets within a bank:
  - 0x00 drive level
  - 0x04 drive enable
  - 0x08 input enable
  - 0x0C output select A
  - 0x10 output select B
  - 0x14 input select A
  - 0x18 level read-back
  - 0x1C rising status
  - 0x20 falling status

  Pins 0..15 use these offsets. Pins 16..31 use the same offsets plus 0x80, with pin k at bit k-16. Reads return the 16 pin bits in [15:0] and zero in [31:16].
- R5: Bits of reserved pins 23, 29, 30 and 31 read as 0 in every register, whatever is written and whatever the pin level is.
- R6: pin_oe equals the drive-enable bit. pin_out equals the drive-level bit while it is enabled, and 0 otherwise.
- R7: The three select registers store their bits independently of each other and of the drive-level register.
- R8: Level read-back is pin_in after a two-flop synchronizer, ANDed with input enable. Writes to the read-back offset have no effect.
- R9: A 0-to-1 change between consecutive read-back samples sets the rising status bit. A 1-to-0 change sets the falling status bit. Both bits stay set until cleared.
- R10: Writing 1 to bit n of a status register clears pin n's status. High-half bits of such a write are ignored. An edge detected in the same cycle keeps the bit set.
- R11: After reset every register bit is 0. A read of any unmapped or misaligned offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address; bit 7 selects the bank |
| bus_wdata | input | 32 | Write data: set half [15:0], clear half [31:16] |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_in | input | 32 | Pin levels from the pads |
| pin_out | output | 32 | Pin drive levels |
| pin_oe | output | 32 | Pin drive enables |

## Verification
A wrong configuration bit appears at pin_out or pin_oe on the cycle after the write. It is also visible on an immediate read-back of the register, so a set/clear decode fault is caught with zero latency. A fault in the synchronizer or in edge capture only shows on the ports two to three cycles after a pin transition. The bench therefore waits four cycles before every read of level or status. A fault that disturbs unselected bits, or the other bank, is exposed by reading back registers the last write did not target.

// File: rtl/gpio_setclr_pkg.sv
// Package: shared widths, register identifiers and the set/clear merge rule.
// Assumes a 32-bit data bus whose two halves each cover one 16-pin bank.
package gpio_setclr_pkg;
    localparam int DATA_W    = 32;
    localparam int BANK_PINS = DATA_W / 2;
    localparam int NUM_CFG   = 6;

    typedef enum logic [3:0] {
        RG_DOUT  = 4'd0,
        RG_DOE   = 4'd1,
        RG_DIE   = 4'd2,
        RG_OSELA = 4'd3,
        RG_OSELB = 4'd4,
        RG_ISELA = 4'd5,
        RG_LVL   = 4'd6,
        RG_RISE  = 4'd7,
        RG_FALL  = 4'd8
    } greg_e;

    localparam logic [3:0] LAST_REG = 4'd8;

    // Merge one set/clear word into a bank register; clear wins.
    function automatic logic [BANK_PINS-1:0] setclr(
        input logic [BANK_PINS-1:0] cur,
        input logic [DATA_W-1:0]    wd
    );
        return (cur | wd[BANK_PINS-1:0]) & ~wd[DATA_W-1:BANK_PINS];
    endfunction
endpackage

// File: rtl/gpio_sync.sv
// Two-flop synchronizer for a vector of asynchronous pin levels.
// Assumes each bit is independent; no bus coherence is implied.
module gpio_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Two-stage capture of the raw pin levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_edge.sv
// Sticky rising/falling edge capture on a synchronized level vector.
// Assumes lvl is already synchronous; clear masks come from W1C writes.
module gpio_edge #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] clr_rise,
    input  logic [W-1:0] clr_fall,
    output logic [W-1:0] rise_q,
    output logic [W-1:0] fall_q
);
    logic [W-1:0] prev_q;
    logic [W-1:0] rise_det, fall_det;

    // Compare the current sample with the previous one.
    always_comb begin
        rise_det = lvl & ~prev_q;
        fall_det = ~lvl & prev_q;
    end

    // Track the previous sample and update the sticky status; a new edge beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            rise_q <= '0;
            fall_q <= '0;
        end else begin
            prev_q <= lvl;
            rise_q <= (rise_q & ~clr_rise) | rise_det;
            fall_q <= (fall_q & ~clr_fall) | fall_det;
        end
    end

    a_r10_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_rise != '0) |=> ((rise_q & $past(clr_rise) & ~($past(lvl) & ~$past(prev_q))) == '0));

    a_r9_rise_needs_level: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise_q & ~$past(rise_q) & ~$past(lvl)) == '0));
endmodule

// File: rtl/gpio_bank.sv
// One 16-pin bank: six set/clear configuration registers, a synchronized,
// input-gated level read-back and sticky edge status with write-one-to-clear.
// Assumes the top decodes address into wr_en/reg_id and routes the bank's pins.
module gpio_bank
    import gpio_setclr_pkg::*;
#(
    parameter logic [BANK_PINS-1:0] RSVD = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  greg_e                reg_id,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [BANK_PINS-1:0] pin_in,
    output logic [BANK_PINS-1:0] rd_val,
    output logic [BANK_PINS-1:0] dout,
    output logic [BANK_PINS-1:0] doe
);
    logic [BANK_PINS-1:0] cfg_q [NUM_CFG];
    logic [BANK_PINS-1:0] sync_lvl, lvl;
    logic [BANK_PINS-1:0] rise_q, fall_q, clr_rise, clr_fall;

    for (genvar k = 0; k < NUM_CFG; k++) begin : g_cfg
        // Hold one configuration register; merge set/clear on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cfg_q[k] <= '0;
            else if (wr_en && reg_id == greg_e'(k))
                cfg_q[k] <= setclr(cfg_q[k], wdata) & ~RSVD;
        end

        a_r1_unselected_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && reg_id == greg_e'(k)) |=> $stable(cfg_q[k]));

        a_r3_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && reg_id == greg_e'(k)) |=> ((cfg_q[k] & $past(wdata[DATA_W-1:BANK_PINS])) == '0));

        a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
            ((cfg_q[k] & RSVD) == '0));
    end

    gpio_sync #(.W(BANK_PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (sync_lvl)
    );

    // Gate the synchronized level by input enable and the reserved mask.
    always_comb lvl = sync_lvl & cfg_q[RG_DIE] & ~RSVD;

    // Turn status-register writes into low-half clear masks.
    always_comb begin
        clr_rise = (wr_en && reg_id == RG_RISE) ? wdata[BANK_PINS-1:0] : '0;
        clr_fall = (wr_en && reg_id == RG_FALL) ? wdata[BANK_PINS-1:0] : '0;
    end

    gpio_edge #(.W(BANK_PINS)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      (lvl),
        .clr_rise (clr_rise),
        .clr_fall (clr_fall),
        .rise_q   (rise_q),
        .fall_q   (fall_q)
    );

    // Select the bank register named by reg_id for reading.
    always_comb begin
        case (reg_id)
            RG_LVL:  rd_val = lvl;
            RG_RISE: rd_val = rise_q;
            RG_FALL: rd_val = fall_q;
            RG_DOUT, RG_DOE, RG_DIE, RG_OSELA, RG_OSELB, RG_ISELA:
                     rd_val = cfg_q[int'(reg_id)];
            default: rd_val = '0;
        endcase
    end

    // Export the pin drive controls.
    always_comb begin
        dout = cfg_q[RG_DOUT];
        doe  = cfg_q[RG_DOE];
    end

    a_r8_level_gated: assert property (@(posedge clk) disable iff (!rst_n)
        ((lvl & ~cfg_q[RG_DIE]) == '0));
endmodule

// File: rtl/gpio_setclr_ctrl.sv
// Top: decodes the register bus across the banks, builds the read mux
// and drives the pins. Assumes NUM_BANKS is a power of two (at least 2)
// and that every access is word-aligned within a 0x80-byte bank window.
module gpio_setclr_ctrl
    import gpio_setclr_pkg::*;
#(
    parameter int                               NUM_BANKS = 2,
    parameter logic [NUM_BANKS*BANK_PINS-1:0]   RSVD_MASK = 32'hE080_0000
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [6+$clog2(NUM_BANKS):0]     bus_addr,
    input  logic [DATA_W-1:0]                bus_wdata,
    input  logic                             bus_we,
    output logic [DATA_W-1:0]                bus_rdata,
    input  logic [NUM_BANKS*BANK_PINS-1:0]   pin_in,
    output logic [NUM_BANKS*BANK_PINS-1:0]   pin_out,
    output logic [NUM_BANKS*BANK_PINS-1:0]   pin_oe
);
    localparam int BSEL_W = $clog2(NUM_BANKS);
    localparam int ADDR_W = 7 + BSEL_W;
    localparam int NPINS  = NUM_BANKS * BANK_PINS;

    logic [BSEL_W-1:0]    bank_sel;
    logic                 mapped;
    greg_e                reg_id;
    logic [BANK_PINS-1:0] bank_rd [NUM_BANKS];
    logic [NPINS-1:0]     dout_all, doe_all;

    // Split the address into bank, register and validity.
    always_comb begin
        bank_sel = bus_addr[ADDR_W-1:7];
        reg_id   = greg_e'(bus_addr[5:2]);
        mapped   = !bus_addr[6] && (bus_addr[1:0] == 2'b00) && (bus_addr[5:2] <= LAST_REG);
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        gpio_bank #(.RSVD(RSVD_MASK[b*BANK_PINS +: BANK_PINS])) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (bus_we && mapped && bank_sel == BSEL_W'(b)),
            .reg_id (reg_id),
            .wdata  (bus_wdata),
            .pin_in (pin_in[b*BANK_PINS +: BANK_PINS]),
            .rd_val (bank_rd[b]),
            .dout   (dout_all[b*BANK_PINS +: BANK_PINS]),
            .doe    (doe_all[b*BANK_PINS +: BANK_PINS])
        );
    end

    // Return the addressed bank's bits, or zero for unmapped offsets.
    always_comb bus_rdata = mapped ? {{(DATA_W-BANK_PINS){1'b0}}, bank_rd[bank_sel]} : '0;

    // Drive a pin's level only while it is enabled.
    always_comb begin
        pin_oe  = doe_all;
        pin_out = dout_all & doe_all;
    end

    a_r6_no_drive_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out & ~pin_oe) == '0));

    a_r4_upper_half_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata[DATA_W-1:BANK_PINS] == '0));
endmodule

// File: tb/sim_gpio_setclr_ctrl.sv
module sim_gpio_setclr_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe;

    int errors = 0;
    int checks = 0;
    logic        rd_pend = 1'b0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    gpio_setclr_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pop an expected item and compare against the read data.
    always @(posedge clk) begin
        #1;
        if (rd_pend && exp_q.size() > 0) begin
            automatic logic [31:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            chk(t, bus_rdata, e);
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    // Driver: present a read address and queue its expected value.
    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        rd_pend = 1'b1;
        @(negedge clk);
        rd_pend = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle(3);
        @(negedge clk) rst_n = 1'b1;
        // R11 reset state
        chk("R11 reset pin_oe", pin_oe, 32'h0);
        chk("R11 reset pin_out", pin_out, 32'h0);
        rd(8'h00, 32'h0, "R11 reset drive level");
        rd(8'h9C, 32'h0, "R11 reset rising status");
        // R1 set
        wr(8'h00, 32'h0000_0005);
        rd(8'h00, 32'h0000_0005, "R1 set bits 0,2");
        // R2 clear
        wr(8'h00, 32'h0001_0000);
        rd(8'h00, 32'h0000_0004, "R2 clear bit 0");
        // R4 high bank
        wr(8'h80, 32'h0000_0003);
        rd(8'h80, 32'h0000_0003, "R4 high bank drive level");
        rd(8'h00, 32'h0000_0004, "R4 low bank untouched");
        // R3 clear wins
        wr(8'h00, 32'h0000_0006);
        wr(8'h00, 32'h0004_0004);
        rd(8'h00, 32'h0000_0002, "R3 clear beats set");
        // R5 reserved
        wr(8'h84, 32'h0000_FFFF);
        rd(8'h84, 32'h0000_1F7F, "R5 reserved enable bits");
        @(negedge clk);
        chk("R5 pin_oe high bank", pin_oe & 32'hFFFF_0000, 32'h1F7F_0000);
        // R6 drive
        wr(8'h04, 32'h0000_0003);
        @(negedge clk);
        chk("R6 pin_oe", pin_oe, 32'h1F7F_0003);
        chk("R6 pin_out", pin_out, 32'h0003_0002);
        wr(8'h04, 32'h0002_0000);
        @(negedge clk);
        chk("R6 disabled pin not driven", pin_out, 32'h0003_0000);
        // R7 select registers
        wr(8'h0C, 32'h0000_00FF);
        wr(8'h10, 32'h0000_0F00);
        wr(8'h14, 32'h0000_F000);
        rd(8'h0C, 32'h0000_00FF, "R7 output select A");
        rd(8'h10, 32'h0000_0F00, "R7 output select B");
        rd(8'h14, 32'h0000_F000, "R7 input select A");
        rd(8'h00, 32'h0000_0002, "R7 drive level intact");
        // R9 edges
        wr(8'h08, 32'h0000_000F);
        idle(4);
        rd(8'h1C, 32'h0, "R9 no edge yet");
        @(negedge clk) pin_in[1] = 1'b1;
        idle(4);
        rd(8'h1C, 32'h0000_0002, "R9 rising captured");
        rd(8'h20, 32'h0, "R9 no falling yet");
        @(negedge clk) pin_in[1] = 1'b0;
        idle(4);
        rd(8'h20, 32'h0000_0002, "R9 falling captured");
        // R10 write-one-to-clear
        wr(8'h1C, 32'hFFFF_0000);
        rd(8'h1C, 32'h0000_0002, "R10 high half ignored");
        wr(8'h1C, 32'h0000_0002);
        rd(8'h1C, 32'h0, "R10 rising cleared");
        rd(8'h20, 32'h0000_0002, "R10 falling kept");
        // R8 read-back
        wr(8'h08, 32'h000F_0000);
        @(negedge clk) pin_in = 32'hFFFF_FFFF;
        idle(4);
        rd(8'h18, 32'h0, "R8 gated by input enable");
        wr(8'h18, 32'h0000_FFFF);
        rd(8'h18, 32'h0, "R8 write ignored");
        wr(8'h08, 32'h0000_00FF);
        idle(4);
        rd(8'h18, 32'h0000_00FF, "R8 enabled level");
        wr(8'h88, 32'h0000_FFFF);
        idle(4);
        rd(8'h98, 32'h0000_1F7F, "R5 reserved level masked");
        // R11 unmapped
        rd(8'h24, 32'h0, "R11 unmapped offset");
        rd(8'h02, 32'h0, "R11 misaligned offset");
        rd(8'hC0, 32'h0, "R11 unmapped high window");
        idle(2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule